// File: doc/BRIEF.md
# Tuner Synthesizer Serial Programming Port

This block is the receive side of a two-wire serial slave that sets up a frequency-synthesizer tuner. The clock and data lines come in as plain levels. A faster system clock oversamples them, and a small front end turns them into bit edges and START/STOP events. The bus master addresses the slave with one write address byte. The two low address bits are strapped by a select input. The master then sends a short run of data bytes. The slave acknowledges each byte it accepts by pulling the data line low through the ninth clock of that byte.

The data bytes are taken in a fixed order: the upper part of the divide ratio, the lower part of the divide ratio, a control byte and a port byte. Each byte has its own output latch, and each latch loads when its byte completes. The divide ratio is a special case: it changes only when its second byte arrives, so a transfer cut short after the first byte leaves the synthesizer's ratio untouched. The control byte is decoded into separate flags for the charge pump, test routing, reference divider and prescaler. The port byte drives five port switches.

Top module: `tuner_pll_prog`

## Requirements
- R1: An address byte whose upper seven bits equal 1,1,0,0,0 followed by `addr_sel[1]`,`addr_sel[0]`, and whose last (eighth) bit is 0 (write), is acknowledged: `sda_pull` is 1 while SCL is high during the ninth clock of that byte.
- R2: An address byte that does not match, or that has its last bit at 1 (read), gets no acknowledge. The slave then ignores all later bytes, with no acknowledge and no latch change, until the next START.
- R3: After an accepted address, every data byte is acknowledged on its ninth clock, including bytes beyond the fourth.
- R4: `divide_ratio` equals {first data byte bits 6:0, second data byte bits 7:0}. Bit 7 of the first byte is ignored. The ratio changes only when the eighth bit of the second data byte is received, so a transfer that ends after the first data byte leaves it unchanged.
- R5: When the third data byte completes, it loads the control flags: bit 6 `cp_high_current`, bit 5 `div_test_route`, bit 4 `cp_disable`, bit 3 `prescaler_en` (0 = prescaler off), bit 2 `drive_disable`, bits 1:0 `ref_div_sel`. Bit 7 is ignored.
- R6: When the fourth data byte completes, its bits 4:0 load `port_en[4:0]` (1 = port on). Bits 7:5 are ignored.
- R7: Data bytes after the fourth change none of the latches.
- R8: A repeated START or a STOP sends the slave back to expecting an address byte. The next data bytes after a new address again start at the first divider byte.
- R9: After reset, all latched outputs are 0 and `sda_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_sel | input | 2 | Strap for the two low address bits |
| sda_pull | output | 1 | 1 = pull the data line low (acknowledge) |
| divide_ratio | output | 15 | Programmable divider ratio |
| cp_high_current | output | 1 | Charge pump high-current select |
| div_test_route | output | 1 | Route divider outputs to test pins |
| cp_disable | output | 1 | Charge pump disabled |
| ref_div_sel | output | 2 | Reference divider ratio select |
| prescaler_en | output | 1 | Prescaler on when 1 |
| drive_disable | output | 1 | Charge-pump drive output disabled |
| port_en | output | 5 | Port switch enables |

## Verification
On every cycle, the assertions check three things. First, each output latch holds unless its own load strobe fired one cycle earlier, and at most one strobe fires at a time. Second, the slave never pulls the data line while it is disengaged. Third, a START always rewinds to the address byte. Only the bench's scenarios can show the rest. These are the acknowledge timing seen on the wired bus line, the exact bit mapping of each byte onto the outputs, that a truncated divider transfer keeps the old ratio, and that mismatched, read and extra bytes leave the outputs alone.

// File: rtl/tpll_pkg.sv
package tpll_pkg;
  localparam int BYTE_W  = 8;
  localparam int RATIO_W = 15;
  localparam int PORT_N  = 5;
  localparam int HI_W    = RATIO_W - BYTE_W;
  localparam logic [4:0] ADDR_FIXED = 5'b11000;

  // byte slots in a transfer
  localparam logic [2:0] SLOT_ADDR  = 3'd0;
  localparam logic [2:0] SLOT_DIVHI = 3'd1;
  localparam logic [2:0] SLOT_DIVLO = 3'd2;
  localparam logic [2:0] SLOT_CTRL  = 3'd3;
  localparam logic [2:0] SLOT_PORT  = 3'd4;
  localparam logic [2:0] SLOT_EXTRA = 3'd5;

  typedef struct packed {
    logic       cp_high;
    logic       div_test;
    logic       cp_off;
    logic       presc_on;
    logic       drive_off;
    logic [1:0] ref_sel;
  } ctrl_t;

  function automatic logic addr_ok(input logic [BYTE_W-1:0] b,
                                   input logic [1:0] sel);
    return (b[7:1] == {ADDR_FIXED, sel}) && (b[0] == 1'b0);
  endfunction

  function automatic ctrl_t decode_ctrl(input logic [BYTE_W-1:0] b);
    ctrl_t c;
    c.cp_high   = b[6];
    c.div_test  = b[5];
    c.cp_off    = b[4];
    c.presc_on  = b[3];
    c.drive_off = b[2];
    c.ref_sel   = b[1:0];
    return c;
  endfunction

  function automatic logic [RATIO_W-1:0] join_ratio(input logic [HI_W-1:0] hi,
                                                    input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/tpll_sync.sv
module tpll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/tpll_link.sv
module tpll_link
  import tpll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [1:0]        addr_sel,
  output logic              sda_pull,
  output logic              active,
  output logic [2:0]        slot,
  output logic              byte_done,
  output logic [2:0]        byte_tag,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_byte;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ack_pend;

  assign next_byte = {shreg[BYTE_W-2:0], sda_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      ack_pend  <= 1'b0;
      sda_pull  <= 1'b0;
      active    <= 1'b0;
      slot      <= SLOT_ADDR;
      byte_done <= 1'b0;
      byte_tag  <= SLOT_ADDR;
      byte_val  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (start_evt || stop_evt) begin
        active   <= start_evt;
        bit_cnt  <= '0;
        slot     <= SLOT_ADDR;
        sda_pull <= 1'b0;
        ack_pend <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (bit_cnt < ACK_BIT) begin
            shreg   <= next_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (slot == SLOT_ADDR) begin
                if (addr_ok(next_byte, addr_sel)) ack_pend <= 1'b1;
                else                              active   <= 1'b0;
              end else begin
                ack_pend  <= 1'b1;
                byte_done <= 1'b1;
                byte_tag  <= slot;
                byte_val  <= next_byte;
              end
            end
          end else if (bit_cnt == ACK_BIT) begin
            bit_cnt <= ACK_DONE;
          end
        end
        if (scl_fall) begin
          if (bit_cnt == ACK_BIT && ack_pend) sda_pull <= 1'b1;
          if (bit_cnt == ACK_DONE) begin
            sda_pull <= 1'b0;
            ack_pend <= 1'b0;
            bit_cnt  <= '0;
            if (slot != SLOT_EXTRA) slot <= slot + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tpll_latch.sv
module tpll_latch
  import tpll_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_done,
  input  logic [2:0]         byte_tag,
  input  logic [BYTE_W-1:0]  byte_val,
  output logic               ratio_load,
  output logic               ctrl_load,
  output logic               port_load,
  output logic [RATIO_W-1:0] ratio,
  output ctrl_t              ctrl,
  output logic [PORT_N-1:0]  ports
);
  logic [HI_W-1:0] hi_hold;
  logic            hi_load;

  assign hi_load    = byte_done && byte_tag == SLOT_DIVHI;
  assign ratio_load = byte_done && byte_tag == SLOT_DIVLO;
  assign ctrl_load  = byte_done && byte_tag == SLOT_CTRL;
  assign port_load  = byte_done && byte_tag == SLOT_PORT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_hold <= '0;
      ratio   <= '0;
      ctrl    <= '0;
      ports   <= '0;
    end else begin
      if (hi_load)    hi_hold <= byte_val[HI_W-1:0];
      if (ratio_load) ratio   <= join_ratio(hi_hold, byte_val);
      if (ctrl_load)  ctrl    <= decode_ctrl(byte_val);
      if (port_load)  ports   <= byte_val[PORT_N-1:0];
    end
  end
endmodule

// File: rtl/tuner_pll_prog.sv
module tuner_pll_prog
  import tpll_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [1:0]         addr_sel,
  output logic               sda_pull,
  output logic [RATIO_W-1:0] divide_ratio,
  output logic               cp_high_current,
  output logic               div_test_route,
  output logic               cp_disable,
  output logic [1:0]         ref_div_sel,
  output logic               prescaler_en,
  output logic               drive_disable,
  output logic [PORT_N-1:0]  port_en
);
  logic sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic link_active, byte_done;
  logic [2:0] slot, byte_tag;
  logic [BYTE_W-1:0] byte_val;
  logic ratio_load, ctrl_load, port_load;
  ctrl_t ctrl;

  tpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  tpll_link u_link (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .active(link_active),
    .slot(slot), .byte_done(byte_done), .byte_tag(byte_tag),
    .byte_val(byte_val)
  );

  tpll_latch u_latch (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_tag(byte_tag),
    .byte_val(byte_val), .ratio_load(ratio_load), .ctrl_load(ctrl_load),
    .port_load(port_load), .ratio(divide_ratio), .ctrl(ctrl), .ports(port_en)
  );

  assign cp_high_current = ctrl.cp_high;
  assign div_test_route  = ctrl.div_test;
  assign cp_disable      = ctrl.cp_off;
  assign prescaler_en    = ctrl.presc_on;
  assign drive_disable   = ctrl.drive_off;
  assign ref_div_sel     = ctrl.ref_sel;
endmodule

// File: rtl/tpll_checker.sv
module tpll_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_evt,
  input logic        link_active,
  input logic        sda_pull,
  input logic [2:0]  slot,
  input logic        ratio_load,
  input logic        ctrl_load,
  input logic        port_load,
  input logic [14:0] divide_ratio,
  input logic [6:0]  ctrl_word,
  input logic [4:0]  port_en
);
  // R4: ratio moves only after its own strobe
  a_r4_ratio_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_load |=> $stable(divide_ratio));
  // R5: control flags move only after the control strobe
  a_r5_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_load |=> $stable(ctrl_word));
  // R6: ports move only after the port strobe
  a_r6_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !port_load |=> $stable(port_en));
  // R7: at most one latch strobe per cycle
  a_r7_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ratio_load, ctrl_load, port_load}));
  // R2: a disengaged slave never pulls the data line
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !link_active |-> !sda_pull);
  // R8: START rewinds to the address slot and releases the line
  a_r8_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (slot == 3'd0 && !sda_pull));
endmodule

bind tuner_pll_prog tpll_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .link_active(link_active),
  .sda_pull(sda_pull), .slot(slot), .ratio_load(ratio_load),
  .ctrl_load(ctrl_load), .port_load(port_load), .divide_ratio(divide_ratio),
  .ctrl_word({cp_high_current, div_test_route, cp_disable, prescaler_en,
              drive_disable, ref_div_sel}),
  .port_en(port_en)
);

// File: tb/tuner_pll_prog_test.sv
module tuner_pll_prog_test;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] sel = 2'b00;
  logic sda_pull;
  logic [14:0] divide_ratio;
  logic cp_high_current, div_test_route, cp_disable, prescaler_en, drive_disable;
  logic [1:0] ref_div_sel;
  logic [4:0] port_en;
  wire sda_bus = m_sda & ~sda_pull;

  int checks = 0, fails = 0;
  logic [14:0] e_ratio = '0;
  logic [6:0]  e_hi = '0;
  logic [6:0]  e_ctrl = '0;
  logic [4:0]  e_port = '0;
  logic [7:0]  tx_data [6];

  always #10 clk = ~clk;

  tuner_pll_prog uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .addr_sel(sel), .sda_pull(sda_pull), .divide_ratio(divide_ratio),
    .cp_high_current(cp_high_current), .div_test_route(div_test_route),
    .cp_disable(cp_disable), .ref_div_sel(ref_div_sel),
    .prescaler_en(prescaler_en), .drive_disable(drive_disable),
    .port_en(port_en)
  );

  function automatic logic bench_addr_good(input logic [7:0] a, input logic [1:0] s);
    return a[7:3] == 5'b11000 && a[2] == s[1] && a[1] == s[0] && a[0] == 1'b0;
  endfunction

  // flags as {cp_high, test_route, cp_off, presc_on, drive_off, ref_sel}
  function automatic logic [6:0] bench_flags(input logic [7:0] b);
    logic [6:0] f;
    for (int i = 0; i < 7; i++) f[i] = b[i];
    return f;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_h(H);
    m_scl = 1'b1; wait_h(H);
    m_sda = 1'b0; wait_h(H);
    m_scl = 1'b0; wait_h(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_h(H);
    m_scl = 1'b1; wait_h(H);
    m_sda = 1'b1; wait_h(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_h(H);
      m_scl = 1'b1; wait_h(H);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wait_h(H);
    m_scl = 1'b1; wait_h(H / 2);
    acked = ~sda_bus;
    wait_h(H - H / 2);
    m_scl = 1'b0;
  endtask

  // bench model of one accepted data byte at position idx (0-based)
  task automatic model_byte(input int idx, input logic [7:0] b);
    case (idx)
      0: e_hi = b[6:0];
      1: e_ratio = {e_hi, b};
      2: e_ctrl = bench_flags(b);
      3: e_port = b[4:0];
      default: ;
    endcase
  endtask

  task automatic check_outputs(input string tag);
    check(divide_ratio == e_ratio, {tag, " R4 ratio"}, divide_ratio, e_ratio);
    check({cp_high_current, div_test_route, cp_disable, prescaler_en,
           drive_disable, ref_div_sel} == e_ctrl, {tag, " R5 ctrl"},
          {cp_high_current, div_test_route, cp_disable, prescaler_en,
           drive_disable, ref_div_sel}, e_ctrl);
    check(port_en == e_port, {tag, " R6 ports"}, port_en, e_port);
  endtask

  // one transfer: address, n data bytes from tx_data, optional stop
  task automatic run_tx(input logic [7:0] a, input int n, input logic do_stop);
    logic ack, good;
    good = bench_addr_good(a, sel);
    bus_start();
    put_byte(a, ack);
    check(ack == good, good ? "R1 address ack" : "R2 address nack", ack, good);
    for (int i = 0; i < n; i++) begin
      put_byte(tx_data[i], ack);
      check(ack == good, good ? "R3 data ack" : "R2 ignored byte", ack, good);
      if (good) model_byte(i, tx_data[i]);
    end
    if (do_stop) bus_stop();
    wait_h(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] ga;
    logic ack;
    void'($urandom(32'h5eed1234));
    wait_h(5);
    rst_n = 1'b1;
    wait_h(5);
    // R9 reset state
    check(sda_pull == 1'b0, "R9 reset pull", sda_pull, 0);
    check_outputs("R9 reset");

    // full transfer, sel=2'b10 (R1 R3 R4 R5 R6)
    sel = 2'b10;
    ga = {5'b11000, sel, 1'b0};
    tx_data[0] = 8'hD5; tx_data[1] = 8'h3C; tx_data[2] = 8'hAA; tx_data[3] = 8'hF5;
    run_tx(ga, 4, 1'b1);
    check_outputs("full");
    check(divide_ratio == 15'h553C, "R4 top bit of first byte ignored", divide_ratio, 15'h553C);

    // wrong address: no ack, nothing changes (R2)
    tx_data[0] = 8'h01; tx_data[1] = 8'h02; tx_data[2] = 8'h7F; tx_data[3] = 8'h1F;
    run_tx({5'b11000, 2'b01, 1'b0}, 4, 1'b1);
    check_outputs("R2 mismatch");

    // read request: no ack (R2)
    run_tx({5'b11000, sel, 1'b1}, 2, 1'b1);
    check_outputs("R2 read");

    // only first divider byte then stop: ratio kept (R4)
    tx_data[0] = 8'h12;
    run_tx(ga, 1, 1'b1);
    check(divide_ratio == 15'h553C, "R4 partial keeps ratio", divide_ratio, 15'h553C);

    // two divider bytes only: ctrl and ports kept (R4)
    tx_data[0] = 8'h0F; tx_data[1] = 8'hE1;
    run_tx(ga, 2, 1'b1);
    check_outputs("R4 two-byte");

    // six bytes: extras acked, ignored (R3 R7)
    tx_data[0] = 8'h7F; tx_data[1] = 8'hFF; tx_data[2] = 8'h15; tx_data[3] = 8'h0A;
    tx_data[4] = 8'hFF; tx_data[5] = 8'hFF;
    run_tx(ga, 6, 1'b1);
    check_outputs("R7 extras");
    check(port_en == 5'h0A, "R7 extras leave ports", port_en, 5'h0A);

    // repeated start after one byte: next data byte is first divider byte (R8)
    tx_data[0] = 8'h44;
    run_tx(ga, 1, 1'b0);
    tx_data[0] = 8'h21; tx_data[1] = 8'h43;
    run_tx(ga, 2, 1'b1);
    check(divide_ratio == 15'h2143, "R8 repeated start rewinds", divide_ratio, 15'h2143);

    // mismatch then repeated start with matching address (R2 R8)
    bus_start();
    put_byte({5'b11000, ~sel, 1'b0}, ack);
    check(ack == 1'b0, "R2 mismatch before restart", ack, 0);
    tx_data[0] = 8'h05; tx_data[1] = 8'h06; tx_data[2] = 8'h48;
    run_tx(ga, 3, 1'b1);
    check_outputs("R8 restart after mismatch");

    // random transfers (R1..R7)
    for (int t = 0; t < 30; t++) begin
      int n;
      sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) < 8) ga = {5'b11000, sel, 1'b0};
      else ga = 8'($urandom);
      n = $urandom_range(0, 6);
      for (int k = 0; k < 6; k++) tx_data[k] = 8'($urandom);
      run_tx(ga, n, 1'b1);
      check_outputs("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule